// File: doc/BRIEF.md
# Host Command Mailbox

A register block that lets a host processor hand commands to an embedded controller. The host sees a small 32-bit register port: a command register that starts a transaction, a status register that reports progress and results, an outbound data window it fills before issuing a command, and an inbound data window it reads back afterwards.

Accepting a command marks the mailbox busy and sends a one-cycle doorbell pulse to the controller, along with the latched command word and read access to the outbound words. The controller finishes the command through a one-cycle completion strobe. That strobe carries an error flag, an 8-bit error code and an initiator tag. The controller can load the inbound words through a separate word-write port. If the host set the interrupt-on-completion bit in its command, completion also sends a one-cycle interrupt pulse back to the host and sets a sticky flag that the host acknowledges by writing the status register.

Top module: `host_mbox`

## Requirements
- R1: After reset, busy, error, the sticky interrupt flag, the error code, the initiator tag, the latched command word, doorbell and host_irq are all zero.
- R2: A host write to address 0x00 while not busy latches the write data on `ctl_cmd`, sets busy (status bit 0) and pulses `doorbell` high for exactly the one cycle after that write edge. Status bits [7:4] then show command bits [15:12], the sub-command id.
- R3: A host write to address 0x00 while busy is ignored. It raises no doorbell and leaves `ctl_cmd` and busy unchanged.
- R4: Host writes to 0x80, 0x84, 0x88 and 0x8C fill outbound words 0 to 3, and the controller reads them on `ctl_obuf_rdata` by `ctl_obuf_idx`. Host reads of 0x00 and of the outbound range return zero.
- R5: The controller word-write port (`ctl_ibuf_we`, `ctl_ibuf_idx`, `ctl_ibuf_wdata`) fills inbound words 0 to 3, and the host reads them at 0x90, 0x94, 0x98 and 0x9C.
- R6: `ctl_done` while busy clears busy and latches the error flag into status bit 1, the error code into status bits [23:16] and the initiator tag into status bits [15:8]. Status bits 3 and [31:24] read zero.
- R7: When the accepted command had bit 8 (interrupt-on-completion) set, completion pulses `host_irq` for exactly one cycle and sets status bit 2. When bit 8 was clear, completion does neither.
- R8: A host write to address 0x04 with data bit 2 set clears status bit 2. A write with bit 2 clear leaves it unchanged, and no status write alters busy, error, code or tag. If a completion sets the flag in the same cycle, the set wins.
- R9: `ctl_done` while not busy is ignored. Status and `host_irq` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address (bits 1:0 ignored) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| host_irq | output | 1 | One-cycle completion interrupt to host |
| doorbell | output | 1 | One-cycle new-command pulse to controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_obuf_idx | input | 2 | Outbound word select |
| ctl_obuf_rdata | output | 32 | Selected outbound word |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Completion error flag |
| ctl_ecode | input | 8 | Completion error code |
| ctl_init_id | input | 8 | Completion initiator tag |
| ctl_ibuf_we | input | 1 | Inbound word write enable |
| ctl_ibuf_idx | input | 2 | Inbound word select |
| ctl_ibuf_wdata | input | 32 | Inbound word data |

## Verification
Seeded random traffic mixes command writes, status writes with bit 2 set and clear, buffer writes, completions with random error values and host reads across the whole decoded range. Because the random stream issues commands and completions without regard to busy, it separates accepted commands from ignored ones and real completions from spurious ones. Directed cases cover interrupt-on-completion set and clear, an acknowledge in the same cycle as a completion, a command write while busy, and reads of write-only locations, which separate the set-wins priority, doorbell suppression and zero read-back from a design that merely latches everything.

// File: rtl/host_mbox.sv
module host_mbox #(
  parameter int NW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_irq,
  output logic        doorbell,
  output logic [31:0] ctl_cmd,
  input  logic [1:0]  ctl_obuf_idx,
  output logic [31:0] ctl_obuf_rdata,
  input  logic        ctl_done,
  input  logic        ctl_err,
  input  logic [7:0]  ctl_ecode,
  input  logic [7:0]  ctl_init_id,
  input  logic        ctl_ibuf_we,
  input  logic [1:0]  ctl_ibuf_idx,
  input  logic [31:0] ctl_ibuf_wdata
);
  localparam int IW = $clog2(NW);
  localparam logic [7:0] A_CMD  = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [3:0] A_OBUF = 4'h8;
  localparam logic [3:0] A_IBUF = 4'h9;
  localparam int IOC_BIT = 8;

  logic [31:0] cmd_q;
  logic        busy_q, err_q, irq_q;
  logic [7:0]  ecode_q, init_q;
  logic [31:0] obuf [NW];
  logic [31:0] ibuf [NW];

  wire [7:0]    word_addr = {host_addr[7:2], 2'b00};
  wire [IW-1:0] hidx      = host_addr[IW+1:2];
  wire          hit_obuf  = host_addr[7:4] == A_OBUF;
  wire          hit_ibuf  = host_addr[7:4] == A_IBUF;
  wire          cmd_acc   = host_wr && word_addr == A_CMD && !busy_q;
  wire          done_acc  = ctl_done && busy_q;
  wire          ack       = host_wr && word_addr == A_STAT && host_wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      ecode_q  <= '0;
      init_q   <= '0;
      doorbell <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      doorbell <= cmd_acc;
      host_irq <= done_acc && cmd_q[IOC_BIT];
      if (cmd_acc) begin
        cmd_q  <= host_wdata;
        busy_q <= 1'b1;
      end
      if (done_acc) begin
        busy_q  <= 1'b0;
        err_q   <= ctl_err;
        ecode_q <= ctl_ecode;
        init_q  <= ctl_init_id;
      end
      if (done_acc && cmd_q[IOC_BIT]) irq_q <= 1'b1;
      else if (ack)                    irq_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        obuf[i] <= '0;
        ibuf[i] <= '0;
      end else begin
        if (host_wr && hit_obuf && hidx == IW'(i)) obuf[i] <= host_wdata;
        if (ctl_ibuf_we && ctl_ibuf_idx == IW'(i)) ibuf[i] <= ctl_ibuf_wdata;
      end
    end
  end

  wire [31:0] status = {8'h00, ecode_q, init_q, cmd_q[15:12], 1'b0, irq_q, err_q, busy_q};

  assign ctl_cmd        = cmd_q;
  assign ctl_obuf_rdata = obuf[ctl_obuf_idx];
  assign host_rdata     = (word_addr == A_STAT) ? status :
                          hit_ibuf              ? ibuf[hidx] : 32'h0;
endmodule

module host_mbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [7:0] host_addr,
  input logic       ctl_done,
  input logic       busy,
  input logic       irq_flag,
  input logic       doorbell,
  input logic       host_irq
);
  wire cmd_wr = host_wr && host_addr[7:2] == 6'd0;

  AST_CMD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> (busy && doorbell)); // R2
  AST_DOORBELL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> busy); // R2
  AST_NO_SECOND_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && !ctl_done) |=> (!doorbell && busy)); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && busy) |=> !busy); // R6
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (irq_flag && !busy)); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq); // R7
  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && !busy) |=> !host_irq); // R9
endmodule

bind host_mbox host_mbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .ctl_done(ctl_done), .busy(busy_q), .irq_flag(irq_q),
  .doorbell(doorbell), .host_irq(host_irq)
);

// File: tb/host_mbox_bench.sv
module host_mbox_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata, ctl_cmd, ctl_obuf_rdata, ctl_ibuf_wdata = 0;
  logic host_irq, doorbell;
  logic [1:0] ctl_obuf_idx = 0, ctl_ibuf_idx = 0;
  logic ctl_done = 0, ctl_err = 0, ctl_ibuf_we = 0;
  logic [7:0] ctl_ecode = 0, ctl_init_id = 0;

  int vectors = 0, errors = 0;
  bit finished = 0;

  host_mbox u_host_mbox (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_busy, m_err, m_irq, e_db, e_hi;
  logic [7:0] m_ecode, m_init;
  logic [31:0] m_cmd;
  logic [31:0] m_ob [4];
  logic [31:0] m_ib [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {8'h00, m_ecode, m_init, m_cmd[15:12], 1'b0, m_irq, m_err, m_busy};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a[7:2] == 6'd1) return exp_status();
    if (a[7:4] == 4'h9) return m_ib[a[3:2]];
    return 32'h0;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_err = 0; m_irq = 0; m_ecode = 0; m_init = 0; m_cmd = 0;
    for (int i = 0; i < 4; i++) begin m_ob[i] = 0; m_ib[i] = 0; end
  endtask

  task automatic tick();
    logic acc, dn, ioc;
    acc = host_wr && host_addr[7:2] == 0 && !m_busy;
    dn  = ctl_done && m_busy;
    ioc = m_cmd[8];
    e_db = acc;
    e_hi = dn && ioc;
    @(posedge clk); #1;
    if (acc) begin m_cmd = host_wdata; m_busy = 1; end
    if (dn) begin m_busy = 0; m_err = ctl_err; m_ecode = ctl_ecode; m_init = ctl_init_id; end
    if (dn && ioc) m_irq = 1;
    else if (host_wr && host_addr[7:2] == 1 && host_wdata[2]) m_irq = 0;
    if (host_wr && host_addr[7:4] == 4'h8) m_ob[host_addr[3:2]] = host_wdata;
    if (ctl_ibuf_we) m_ib[ctl_ibuf_idx] = ctl_ibuf_wdata;
    host_wr = 0; ctl_done = 0; ctl_ibuf_we = 0;
    chk(doorbell == e_db, "R2/R3 doorbell", 32'(doorbell), 32'(e_db));
    chk(host_irq == e_hi, "R7/R9 host_irq", 32'(host_irq), 32'(e_hi));
    chk(ctl_cmd == m_cmd, "R2/R3 ctl_cmd", ctl_cmd, m_cmd);
    host_addr = 8'h04; #1;
    chk(host_rdata == exp_status(), "R6/R8 status", host_rdata, exp_status());
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick();
  endtask

  task automatic done(input logic e, input logic [7:0] c, input logic [7:0] t);
    ctl_done = 1; ctl_err = e; ctl_ecode = c; ctl_init_id = t; tick();
  endtask

  task automatic hread(input logic [7:0] a, input string req);
    host_addr = a; #1;
    chk(host_rdata == exp_rd(a), req, host_rdata, exp_rd(a));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; vectors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    host_addr = 8'h04; #1;
    chk(host_rdata == 0, "R1 status after reset", host_rdata, 0);
    chk(!doorbell && !host_irq && ctl_cmd == 0, "R1 outputs after reset",
        {doorbell, host_irq, ctl_cmd[29:0]}, 0);

    // R4 outbound fill and controller read-back; write-only reads zero
    for (int i = 0; i < 4; i++) hwrite(8'h80 + 8'(4*i), 32'hA0B0_0000 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      ctl_obuf_idx = 2'(i); #1;
      chk(ctl_obuf_rdata == m_ob[i], "R4 outbound word", ctl_obuf_rdata, m_ob[i]);
      hread(8'h80 + 8'(4*i), "R4 outbound reads zero");
    end
    // R5 inbound
    for (int i = 0; i < 4; i++) begin
      ctl_ibuf_we = 1; ctl_ibuf_idx = 2'(i); ctl_ibuf_wdata = 32'hC0DE_0000 + 32'(i); tick();
    end
    for (int i = 0; i < 4; i++) hread(8'h90 + 8'(4*i), "R5 inbound word");

    // R2 command with ioc, R3 second write ignored
    hwrite(8'h00, 32'h0003_51FF);
    hread(8'h00, "R4 command reads zero");
    hwrite(8'h00, 32'h0000_0022);
    // R9-style spurious ack while busy leaves busy
    hwrite(8'h04, 32'hFFFF_FFFB);
    // R6/R7 completion with error
    done(1, 8'h5A, 8'h3C);
    tick();
    // R8 ack with bit2 clear keeps flag, then set clears
    hwrite(8'h04, 32'h0000_0000);
    hwrite(8'h04, 32'h0000_0004);
    // R9 completion while idle ignored
    done(0, 8'hEE, 8'h11);
    // R7 ioc clear: no interrupt
    hwrite(8'h00, 32'h0004_2010);
    done(0, 8'h00, 8'h07);
    // R8 ack and completion same cycle: set wins
    hwrite(8'h00, 32'h0004_7101);
    host_wr = 1; host_addr = 8'h04; host_wdata = 32'h4;
    ctl_done = 1; ctl_err = 0; ctl_ecode = 8'h12; ctl_init_id = 8'h34; tick();

    // random traffic over R2..R9
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: hwrite(8'h00, $urandom());
        1: hwrite(8'h04, $urandom());
        2: hwrite(8'h80 + 8'(4 * $urandom_range(0, 3)), $urandom());
        3: begin
             ctl_ibuf_we = 1; ctl_ibuf_idx = 2'($urandom_range(0, 3));
             ctl_ibuf_wdata = $urandom(); tick();
           end
        4, 5: done(1'($urandom()), 8'($urandom()), 8'($urandom()));
        default: begin
             ctl_obuf_idx = 2'($urandom_range(0, 3)); #1;
             chk(ctl_obuf_rdata == m_ob[ctl_obuf_idx], "R4 random outbound",
                 ctl_obuf_rdata, m_ob[ctl_obuf_idx]);
             hread(8'($urandom_range(0, 255)), "R4/R5 random read");
           end
      endcase
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule